// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block produces the two low address bits for a four-beat burst into a memory word array. A load strobe captures a starting offset together with the upper address bits. After that, every clock on which the active-low advance input is asserted moves the offset one beat further through a block of four words, wrapping inside that block. When advance is deasserted the offset holds, so the same word is accessed again. This is the suspend case.

The order of the beats is picked by a mode input. In linear order the start offset is incremented modulo four. In interleaved order the start offset is XORed with the beat number. Internally the block keeps only the captured start offset and a two-bit beat count. The visible offset is formed combinationally from those two registers and the mode input, so a change of mode takes effect at once without disturbing the beat count.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted, and on leaving it, `offset` is 00 and `upper_q` is all zeros.
- R2: On a clock edge with `load` high, the beat count restarts, and after that edge `offset` equals the `start_off` value that was sampled.
- R3: With `mode_il` low (linear), after n advances from start s, `offset` is (s + n) mod 4.
- R4: With `mode_il` high (interleaved), after n advances from start s, `offset` is s XOR n, with n taken as two bits. For example, start 01 runs 01, 00, 11, 10.
- R5: The beat count advances only on a clock edge where `adv_n` is 0 and `load` is 0.
- R6: On an edge with `adv_n` = 1 and `load` = 0, `offset` is held (suspend).
- R7: A `load` reloads the start offset even when `adv_n` is 0 on the same edge, and no advance happens on that edge.
- R8: `upper_q` takes `upper_in` on a load edge and is unchanged on every other edge.
- R9: After four advances, `offset` returns to the start value in either mode.
- R10: A change of `mode_il` during a burst switches `offset` to the other order at the current beat, in the same cycle, and leaves the beat count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start of a new access; captures the start offset and the upper bits |
| start_off | input | 2 | Starting word offset within the four-word block |
| upper_in | input | UW | Upper address bits of the access |
| adv_n | input | 1 | Advance request, active low |
| mode_il | input | 1 | Beat order: 1 selects interleaved, 0 selects linear |
| offset | output | 2 | Current word offset |
| upper_q | output | UW | Registered upper address bits |

## Verification
The bench runs every start offset in both orders through a full burst, including the wrap on the fourth beat. A design that swapped the two orders, or that carried into a third bit, would show the wrong sequence already by the second beat. Suspend cycles are placed inside bursts, so a counter that ignored `adv_n` would be seen moving. A load made while advance is asserted checks that the load takes priority; a design that advanced on the load edge would show start+1. A mode flip in the middle of a burst checks that the beat count survives the switch and that the new order appears in the same cycle.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int UW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    start_off,
  input  logic [UW-1:0] upper_in,
  input  logic          adv_n,
  input  logic          mode_il,
  output logic [1:0]    offset,
  output logic [UW-1:0] upper_q
);
  localparam int OW = 2;

  logic [OW-1:0] base_q;
  logic [OW-1:0] beat_q;
  logic [UW-1:0] up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      up_q   <= '0;
    end else if (load) begin
      base_q <= start_off;
      beat_q <= '0;
      up_q   <= upper_in;
    end else if (!adv_n) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign offset  = mode_il ? (base_q ^ beat_q) : OW'(base_q + beat_q);
  assign upper_q = up_q;
endmodule

module burst_seq_chk #(
  parameter int UW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [1:0]    start_off,
  input logic [UW-1:0] upper_in,
  input logic          adv_n,
  input logic          mode_il,
  input logic [1:0]    offset,
  input logic [UW-1:0] upper_q
);
  AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> offset == $past(start_off)); // R2
  AST_LOAD_BEATS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !adv_n) |=> offset == $past(start_off)); // R7
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> (mode_il != $past(mode_il)) || (offset == $past(offset))); // R6
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && !mode_il) |=> mode_il || (offset == 2'($past(offset) + 2'd1))); // R3
  AST_IL_LOW_BIT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && mode_il) |=> !mode_il || (offset[0] != $past(offset[0]))); // R4
  AST_UPPER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> upper_q == $past(upper_in)); // R8
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(upper_q)); // R8
endmodule

bind burst_seq burst_seq_chk #(.UW(UW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .start_off(start_off),
  .upper_in(upper_in), .adv_n(adv_n), .mode_il(mode_il),
  .offset(offset), .upper_q(upper_q)
);

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  localparam int UW = 15;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [1:0]    start_off = '0;
  logic [UW-1:0] upper_in = '0;
  logic          adv_n = 1'b1;
  logic          mode_il = 1'b0;
  logic [1:0]    offset;
  logic [UW-1:0] upper_q;

  int errors = 0;
  int checks = 0;

  burst_seq #(.UW(UW)) u_burst_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .start_off(start_off),
    .upper_in(upper_in), .adv_n(adv_n), .mode_il(mode_il),
    .offset(offset), .upper_q(upper_q)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_off(input int m, input int s, input int n);
    return m ? ((s ^ n) & 3) : ((s + n) & 3);
  endfunction

  task automatic do_load(input int s, input int up, input logic adv);
    load = 1'b1; start_off = 2'(s); upper_in = UW'(up); adv_n = adv;
    @(negedge clk);
    load = 1'b0; adv_n = 1'b1; upper_in = '0;
  endtask

  task automatic advance();
    adv_n = 1'b0;
    @(negedge clk);
    adv_n = 1'b1;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 offset in reset", offset, 0);
    chk("R1 upper in reset", upper_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 offset after reset", offset, 0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        mode_il = m[0];
        do_load(s, 100 * s + 7 * m + 1, 1'b1);
        chk("R2 start captured", offset, s);
        chk("R8 upper captured", upper_q, 100 * s + 7 * m + 1);
        for (int n = 1; n <= 4; n++) begin
          advance();
          chk(m ? "R4 interleaved beat" : "R3 linear beat", offset, expect_off(m, s, n));
          if (n == 4) chk("R9 wrap to start", offset, s);
          if (n == 2) begin
            @(negedge clk);
            @(negedge clk);
            chk("R6 suspend holds", offset, expect_off(m, s, 2));
          end
        end
        chk("R8 upper held over burst", upper_q, 100 * s + 7 * m + 1);
      end
    end

    mode_il = 1'b0;
    do_load(1, 5, 1'b1);
    advance();
    chk("R5 one advance", offset, 2);
    load = 1'b0; adv_n = 1'b1;
    @(negedge clk);
    chk("R5 no advance with adv_n high", offset, 2);
    do_load(2, 9, 1'b0);
    chk("R7 load wins over advance", offset, 2);
    chk("R7 upper on loaded edge", upper_q, 9);
    advance();
    chk("R7 next advance from start", offset, 3);

    do_load(1, 3, 1'b1);
    advance();
    chk("R10 linear at beat 1", offset, 2);
    mode_il = 1'b1;
    #1;
    chk("R10 flip to interleaved same cycle", offset, 0);
    @(negedge clk);
    advance();
    chk("R10 beat kept across flip", offset, 3);
    advance();
    chk("R10 interleaved at beat 3", offset, 2);
    mode_il = 1'b0;
    #1;
    chk("R10 flip back to linear", offset, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule